// File: doc/BRIEF.md
# Gate driver fault supervisor

This block watches the protection comparators of a half-bridge gate driver and turns their flags into three results: an active-high fault flag, separate inhibit lines for the high-side and low-side drivers, and a sleep request for the power-management logic. It takes four raw comparator flags and the active-low control line. The flags are: gate-supply undervoltage, reference undervoltage, bootstrap undervoltage and overtemperature. Every input passes through a synchronizer before any decision is made.

Each fault class has its own policy. The gate-supply undervoltage and overtemperature faults are held in latches. The reference and bootstrap undervoltage faults are reported only while they are present. Any undervoltage of a supply rail blocks both drivers. A weak bootstrap blocks only the high side. Overtemperature blocks nothing and only reports.

The control line serves two purposes, and the length of its low time decides which. A low time of at least `CLR_MIN_CYC` cycles clears the latches. A low time longer than `SLEEP_CYC` cycles requests sleep. After sleep, the drivers stay blocked and the fault flag stays raised until both supply rails have been seen healthy.

Top module: `gdrv_fault_sup`

## Requirements
- R1: `fault_o` is 0 whenever the synchronized control line is low. While the line is high, `fault_o` is 1 exactly when a flag is present, a latch is set, or a wake-up is pending.
- R2: Gate-supply undervoltage raises `inh_lo_o` and `inh_hi_o` and sets a latch that keeps `fault_o` at 1. Both inhibits drop as soon as the synchronized flag clears, even while the latch still holds the fault.
- R3: Reference undervoltage raises both inhibits and `fault_o` only while it is present. It leaves no latch behind.
- R4: Overtemperature sets a latch that keeps `fault_o` at 1. It never raises either inhibit.
- R5: Bootstrap undervoltage raises `inh_hi_o` and `fault_o` only while it is present. It leaves `inh_lo_o` at 0 and sets no latch. Whenever `inh_lo_o` is 1, `inh_hi_o` is also 1.
- R6: While the synchronized control line is low, both inhibits are 1 and `fault_o` is 0. A low time of `CLR_MIN_CYC` cycles or more clears both latches. A low time of `CLR_MIN_CYC`-1 cycles leaves them unchanged.
- R7: `sleep_req_o` rises once the synchronized control line has been low for more than `SLEEP_CYC` cycles. It stays at 1 until the line returns high. A low time of exactly `SLEEP_CYC` cycles never raises it.
- R8: After a sleep request, both inhibits and `fault_o` stay at 1 with the line high until both supply undervoltage flags are seen clear. The drivers are released one cycle after that.
- R9: Each input reaches the decision logic after `SYNC_STAGES` clock edges. A flag changed just after one edge affects the combinational outputs after the second edge that follows, with the default of 2 stages.
- R10: A latched fault whose flag is still present when the control line returns high is latched again. `fault_o` then stays at 1 after the flag goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_gate_i | input | 1 | Raw gate-supply undervoltage flag |
| uv_ref_i | input | 1 | Raw reference undervoltage flag |
| uv_boot_i | input | 1 | Raw bootstrap undervoltage flag |
| ot_i | input | 1 | Raw overtemperature flag |
| ctrl_run_i | input | 1 | Control line: high runs, low clears or sleeps |
| fault_o | output | 1 | Fault flag, active high |
| inh_hi_o | output | 1 | High-side driver inhibit |
| inh_lo_o | output | 1 | Low-side driver inhibit |
| sleep_req_o | output | 1 | Sleep request |

## Verification
The bench first sweeps all sixteen combinations of the four fault flags with the line high. After each combination it removes the flags and then clears with a qualified pulse. This separates each class's inhibit pattern from its latch policy. The control-line tests place pulses of `CLR_MIN_CYC`-1 and `CLR_MIN_CYC` cycles, and low times of `SLEEP_CYC` and more than `SLEEP_CYC` cycles, on both sides of each threshold. Further tests check the re-latch of a persistent flag, the wake-up hold while the reference rail is still low, and the synchronizer latency cycle by cycle.

// File: rtl/gdrv_fault_pkg.sv
package gdrv_fault_pkg;
   // bit positions inside the synchronized flag vector
   localparam int FLG_UVG = 0;
   localparam int FLG_UVR = 1;
   localparam int FLG_UVB = 2;
   localparam int FLG_OT  = 3;
   localparam int FLG_RUN = 4;
   localparam int NFLG    = 5;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gdrv_low_timer.sv
module gdrv_low_timer #(
   parameter int CLR_MIN_CYC = 250,
   parameter int SLEEP_CYC   = 2500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_s_i,
   output logic qual_clr_o,
   output logic sleep_set_o,
   output logic sleep_o
);
   import gdrv_fault_pkg::*;
   localparam int CW = cnt_width(SLEEP_CYC);
   localparam logic [CW-1:0] SAT_V = CW'(SLEEP_CYC);
   localparam logic [CW-1:0] CLR_V = CW'(CLR_MIN_CYC - 1);

   logic [CW-1:0] low_cnt;
   logic          slp_q;

   // low_cnt holds the number of earlier low cycles; this edge is low_cnt+1
   assign qual_clr_o  = !run_s_i && (low_cnt >= CLR_V);
   assign sleep_set_o = !run_s_i && (low_cnt >= SAT_V);
   assign sleep_o     = slp_q && !run_s_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         low_cnt <= '0;
         slp_q   <= 1'b0;
      end else if (run_s_i) begin
         low_cnt <= '0;
         slp_q   <= 1'b0;
      end else begin
         if (low_cnt != SAT_V) low_cnt <= low_cnt + 1'b1;
         if (sleep_set_o)      slp_q   <= 1'b1;
      end
   end
endmodule

// File: rtl/gdrv_fault_policy.sv
module gdrv_fault_policy (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_s_i,
   input  logic uvg_s_i,
   input  logic uvr_s_i,
   input  logic uvb_s_i,
   input  logic ot_s_i,
   input  logic qual_clr_i,
   input  logic sleep_set_i,
   output logic lat_uvg_o,
   output logic lat_ot_o,
   output logic wake_o,
   output logic fault_o,
   output logic inh_hi_o,
   output logic inh_lo_o
);
   logic rails_ok;
   assign rails_ok = !uvg_s_i && !uvr_s_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat_uvg_o <= 1'b0;
         lat_ot_o  <= 1'b0;
         wake_o    <= 1'b0;
      end else begin
         // a qualified low time wins over any set
         if (qual_clr_i)              lat_uvg_o <= 1'b0;
         else if (run_s_i && uvg_s_i) lat_uvg_o <= 1'b1;
         if (qual_clr_i)              lat_ot_o  <= 1'b0;
         else if (run_s_i && ot_s_i)  lat_ot_o  <= 1'b1;
         if (sleep_set_i)              wake_o    <= 1'b1;
         else if (run_s_i && rails_ok) wake_o    <= 1'b0;
      end
   end

   assign fault_o  = run_s_i && (uvg_s_i || uvr_s_i || uvb_s_i || ot_s_i ||
                                 lat_uvg_o || lat_ot_o || wake_o);
   assign inh_lo_o = !run_s_i || !rails_ok || wake_o;
   assign inh_hi_o = inh_lo_o || uvb_s_i;
endmodule

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
   parameter int SYNC_STAGES = 2,
   parameter int CLR_MIN_CYC = 250,
   parameter int SLEEP_CYC   = 2500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic uv_gate_i,
   input  logic uv_ref_i,
   input  logic uv_boot_i,
   input  logic ot_i,
   input  logic ctrl_run_i,
   output logic fault_o,
   output logic inh_hi_o,
   output logic inh_lo_o,
   output logic sleep_req_o
);
   import gdrv_fault_pkg::*;

   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
      assert (CLR_MIN_CYC >= 1)
         else $error("CLR_MIN_CYC must be at least 1");
      assert (SLEEP_CYC > CLR_MIN_CYC)
         else $error("SLEEP_CYC must exceed CLR_MIN_CYC");
   end

   logic [NFLG-1:0] raw_v, syn_v;
   logic run_s, uvg_s, uvr_s, uvb_s, ot_s;
   logic qual_clr, sleep_set;
   logic lat_uvg, lat_ot, wake;

   always_comb begin
      raw_v          = '0;
      raw_v[FLG_UVG] = uv_gate_i;
      raw_v[FLG_UVR] = uv_ref_i;
      raw_v[FLG_UVB] = uv_boot_i;
      raw_v[FLG_OT]  = ot_i;
      raw_v[FLG_RUN] = ctrl_run_i;
   end

   gdrv_sync #(.W(NFLG), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_v),
      .q_o   (syn_v)
   );

   assign run_s = syn_v[FLG_RUN];
   assign uvg_s = syn_v[FLG_UVG];
   assign uvr_s = syn_v[FLG_UVR];
   assign uvb_s = syn_v[FLG_UVB];
   assign ot_s  = syn_v[FLG_OT];

   gdrv_low_timer #(.CLR_MIN_CYC(CLR_MIN_CYC), .SLEEP_CYC(SLEEP_CYC)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_s_i    (run_s),
      .qual_clr_o (qual_clr),
      .sleep_set_o(sleep_set),
      .sleep_o    (sleep_req_o)
   );

   gdrv_fault_policy u_pol (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_s_i    (run_s),
      .uvg_s_i    (uvg_s),
      .uvr_s_i    (uvr_s),
      .uvb_s_i    (uvb_s),
      .ot_s_i     (ot_s),
      .qual_clr_i (qual_clr),
      .sleep_set_i(sleep_set),
      .lat_uvg_o  (lat_uvg),
      .lat_ot_o   (lat_ot),
      .wake_o     (wake),
      .fault_o    (fault_o),
      .inh_hi_o   (inh_hi_o),
      .inh_lo_o   (inh_lo_o)
   );
endmodule

// File: rtl/gdrv_fault_chk.sv
module gdrv_fault_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic run_s,
   input logic uvg_s,
   input logic uvb_s,
   input logic ot_s,
   input logic lat_uvg,
   input logic lat_ot,
   input logic fault_o,
   input logic inh_hi_o,
   input logic inh_lo_o,
   input logic sleep_req_o
);
   p_fault_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_s |-> !fault_o);

   p_gate_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_s && uvg_s) |=> (fault_o || !run_s));

   p_ot_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_s && ot_s) |=> (fault_o || !run_s));

   p_side_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inh_lo_o |-> inh_hi_o);

   p_boot_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uvb_s |-> inh_hi_o);

   p_low_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_s |-> (inh_lo_o && inh_hi_o));

   p_sleep_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_req_o |-> (!run_s && !lat_uvg && !lat_ot));

   p_wake_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_s && $past(sleep_req_o)) |-> (inh_lo_o && fault_o));
endmodule

bind gdrv_fault_sup gdrv_fault_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .run_s      (run_s),
   .uvg_s      (uvg_s),
   .uvb_s      (uvb_s),
   .ot_s       (ot_s),
   .lat_uvg    (lat_uvg),
   .lat_ot     (lat_ot),
   .fault_o    (fault_o),
   .inh_hi_o   (inh_hi_o),
   .inh_lo_o   (inh_lo_o),
   .sleep_req_o(sleep_req_o)
);

// File: tb/gdrv_fault_sup_test.sv
`timescale 1ns/1ps
module gdrv_fault_sup_test;
   localparam int CLR  = 4;
   localparam int SLP  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uvg = 0, uvr = 0, uvb = 0, ot = 0, run = 1;
   logic fault, inh_hi, inh_lo, sleep;
   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gdrv_fault_sup #(.SYNC_STAGES(2), .CLR_MIN_CYC(CLR), .SLEEP_CYC(SLP)) uut (
      .clk_i(clk), .rst_ni(rst_n), .uv_gate_i(uvg), .uv_ref_i(uvr),
      .uv_boot_i(uvb), .ot_i(ot), .ctrl_run_i(run),
      .fault_o(fault), .inh_hi_o(inh_hi), .inh_lo_o(inh_lo), .sleep_req_o(sleep)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic low_pulse(input int n);
      run = 1'b0;
      tick(n);
      run = 1'b1;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      tick(1);
      // reset state: line not yet seen high
      chk("R1 reset fault", fault, 1'b0);
      chk("R6 reset inh_lo", inh_lo, 1'b1);
      chk("R6 reset inh_hi", inh_hi, 1'b1);
      chk("R7 reset sleep", sleep, 1'b0);
      tick(2);
      rst_n = 1'b1;
      tick(4);
      chk("R1 idle fault", fault, 1'b0);
      chk("R2 idle inh_lo", inh_lo, 1'b0);

      // exhaustive sweep of the four flags
      for (int v = 0; v < 16; v++) begin
         logic eg, er, eb, eo;
         eg = v[0]; er = v[1]; eb = v[2]; eo = v[3];
         {ot, uvb, uvr, uvg} = 4'(v);
         tick(4);
         chk("R1 sweep fault present", fault, eg | er | eb | eo);
         chk("R3 sweep inh_lo present", inh_lo, eg | er);
         chk("R5 sweep inh_hi present", inh_hi, eg | er | eb);
         {ot, uvb, uvr, uvg} = 4'b0;
         tick(4);
         chk("R4 sweep fault after removal", fault, eg | eo);
         chk("R2 sweep inh_lo after removal", inh_lo, 1'b0);
         chk("R5 sweep inh_hi after removal", inh_hi, 1'b0);
         run = 1'b0;
         tick(3);
         chk("R6 low fault", fault, 1'b0);
         chk("R6 low inh_lo", inh_lo, 1'b1);
         chk("R6 low inh_hi", inh_hi, 1'b1);
         tick(CLR - 3);
         run = 1'b1;
         tick(4);
         chk("R6 cleared after qualified pulse", fault, 1'b0);
      end

      // R6: pulse one cycle short leaves the latch, full pulse clears
      ot = 1'b1; tick(4); ot = 1'b0; tick(4);
      low_pulse(CLR - 1); tick(4);
      chk("R6 short pulse keeps latch", fault, 1'b1);
      low_pulse(CLR); tick(4);
      chk("R6 full pulse clears latch", fault, 1'b0);

      // R10: flag still present at return re-latches
      uvg = 1'b1; tick(4);
      low_pulse(CLR); tick(4);
      chk("R10 present after clear", fault, 1'b1);
      uvg = 1'b0; tick(4);
      chk("R10 re-latched fault", fault, 1'b1);
      chk("R2 drivers released while latched", inh_lo, 1'b0);
      low_pulse(CLR); tick(4);
      chk("R10 cleared", fault, 1'b0);

      // R9: latency through the synchronizer
      uvr = 1'b1; tick(1);
      chk("R9 one edge no effect", inh_lo, 1'b0);
      tick(1);
      chk("R9 two edges effect", inh_lo, 1'b1);
      uvr = 1'b0; tick(4);
      chk("R3 no latch left", fault, 1'b0);

      // R7: exactly SLP low cycles never requests sleep
      begin
         logic seen = 1'b0;
         run = 1'b0;
         for (int i = 0; i < SLP + 4; i++) begin
            if (i == SLP) run = 1'b1;
            tick(1);
            seen = seen | sleep;
         end
         chk("R7 no sleep at threshold", seen, 1'b0);
      end
      tick(4);

      // R7/R8: long low requests sleep, wake held by reference rail
      ot = 1'b1; tick(4); ot = 1'b0;
      run = 1'b0;
      tick(SLP + 4);
      chk("R7 sleep requested", sleep, 1'b1);
      chk("R7 fault low in sleep", fault, 1'b0);
      uvr = 1'b1;
      run = 1'b1;
      tick(4);
      chk("R7 sleep dropped", sleep, 1'b0);
      chk("R8 wake fault", fault, 1'b1);
      chk("R8 wake inh_lo", inh_lo, 1'b1);
      chk("R8 wake inh_hi", inh_hi, 1'b1);
      uvr = 1'b0;
      tick(2);
      chk("R8 held one more cycle", inh_lo, 1'b1);
      tick(1);
      chk("R8 released inh_lo", inh_lo, 1'b0);
      chk("R8 released inh_hi", inh_hi, 1'b0);
      chk("R8 fault gone, sleep cleared latch", fault, 1'b0);

      done = 1;
      summary();
      $finish;
   end
endmodule